// File: doc/BRIEF.md
# Floppy Controller Host Register File

This block holds the byte-wide registers a host sees at offsets 0 to 4 and 7 of a PC floppy controller window. It decodes host reads and writes, keeps the control registers (drive/motor control, tape select, data rate, precompensation, power-down, and a configuration bit with no side effect), and builds the status bytes from the drive-side pin levels. The command engine, the data FIFO at offset 5 and the data separator are outside it. A read of offset 4 returns a main-status byte supplied from outside.

The same offset decodes differently in each of three personalities, picked by a two-bit mode input:
- 00 or 11: PC-AT.
- 01: PS/2.
- 10: Model 30.

The status bytes show pin levels in one sense or the other. They also carry activity bits. In PS/2 mode these bits toggle on pin edges. In Model 30 mode they are sticky, and a host read of offset 7 clears them. All drive-side pins pass through a two-flop synchronizer. Edges are taken from the synchronized value and the value one cycle older. Pin inputs are active-low levels, and an idle pin is 1.

Top module: `fdc_host_regs`

## Requirements
- R1: After reset the outputs are as follows:
  - `ctrl_reset` is 1, because the drive control register is 00h.
  - `motor_a`, `power_down` and `precomp` are 0.
  - `data_rate` is 10b.
  - `dma_irq_en` is 0 in mode 00.
  - With all pins at 1, offset 0 in mode 10 reads 09h.
- R2: Offset 0 in mode 01 reads the following (bit 7 first):
  - bit 7: `irq_pend`
  - bit 6: 1
  - bit 5: not STEP#
  - bit 4: TRK0#
  - bit 3: not HDSEL#
  - bit 2: INDEX#
  - bit 1: WPT#
  - bit 0: not DIR#

  In modes 00 and 11, offsets 0 and 1 read FFh.
- R3: Offset 0 in mode 10 reads the following (bit 7 first):
  - bit 7: `irq_pend`
  - bit 6: `drq`
  - bit 5: the step latch, set by a falling edge of STEP#
  - bit 4: not TRK0#
  - bit 3: HDSEL#
  - bit 2: not INDEX#
  - bit 1: not WPT#
  - bit 0: DIR#
- R4: Offset 1 in mode 01 reads the following (bit 7 first):
  - bits 7-6: 11b
  - bit 5: drive control bit 0
  - bit 4: toggles on every rising edge of WDATA#
  - bit 3: toggles on every rising edge of RDATA#
  - bit 2: not WGATE#
  - bit 1: 0
  - bit 0: drive control bit 4
- R5: Offset 1 in mode 10 reads the following (bit 7 first):
  - bits 7-6: 11b
  - bit 5: not `drive_sel_a`
  - bit 4: set by a rising edge of WDATA#
  - bit 3: set by a rising edge of RDATA#
  - bit 2: set by a falling edge of WGATE#, and not by a rising edge
  - bits 1-0: 11b

  Bits 4, 3 and 2 stay set until the host reads offset 7.
- R6: A write to offset 2 stores bits 5-0. A read of offset 2 returns them with bits 7-6 as 0.
  - `motor_a` equals bit 4.
  - `drive_sel_a` is 1 when bits 1-0 are 00b.
  - `ctrl_reset` is 1 while bit 2 is 0.
  - Bit 5 drives no output.
- R7: `dma_irq_en` equals bit 3 of offset 2 in modes 00, 10 and 11, and is 1 in mode 01.
- R8: A write to offset 3 stores bits 1-0. A read of offset 3 returns `{2'b00, 2'b11, 2'b11, sel}`.
- R9: A write to offset 4 sets `precomp` from bits 4-2, `power_down` from bit 6 and `data_rate` from bits 1-0. If bit 7 is 1, `ctrl_reset` is 1 for exactly the next cycle and then returns to the drive-control value.
- R10: `data_rate` follows bits 1-0 of whichever of offset 4 or offset 7 was written last. It changes on no other access.
- R11: A read of offset 7 returns the following:
  - Modes 00 and 11: `{~DSKCHG#, 7'b0}`.
  - Mode 01: `{~DSKCHG#, 4'b1111, rate, rate[1]^rate[0]}`.
  - Mode 10: `{DSKCHG#, 3'b000, offset-2 bit 3, nopre, rate}`.
- R12: Bit 2 of a write to offset 7 sets `nopre` only in mode 10. It is read back as in R11 and changes no output.
- R13: A read of offset 4 returns `msr_in`. Offsets 5 and 6 read 00h.
- R14: A pin level shows in the status bytes after two rising clock edges. An edge-derived bit changes after three.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode | input | 2 | Personality: 00/11 PC-AT, 01 PS/2, 10 Model 30 |
| host_addr | input | 3 | Register offset |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Read strobe (used to clear sticky bits on offset 7) |
| host_wr | input | 1 | Write strobe |
| host_rdata | output | 8 | Read data for `host_addr` |
| msr_in | input | 8 | External main-status byte returned at offset 4 |
| step_n | input | 1 | STEP# level |
| dir_n | input | 1 | DIR# level |
| hdsel_n | input | 1 | HDSEL# level |
| wgate_n | input | 1 | WGATE# level |
| wdata_n | input | 1 | WDATA# level |
| rdata_n | input | 1 | RDATA# level |
| trk0_n | input | 1 | TRK0# level |
| index_n | input | 1 | INDEX# level |
| wpt_n | input | 1 | WPT# level |
| dskchg_n | input | 1 | DSKCHG# level |
| irq_pend | input | 1 | Interrupt output state |
| drq | input | 1 | DMA request state |
| motor_a | output | 1 | Motor A enable |
| drive_sel_a | output | 1 | Drive A selected |
| ctrl_reset | output | 1 | Controller reset, active high |
| dma_irq_en | output | 1 | DMA and interrupt gate |
| data_rate | output | 2 | Selected data rate code |
| precomp | output | 3 | Write precompensation select |
| power_down | output | 1 | Power-down request |

## Verification
The Model 30 step latch and sticky activity bits are the hardest state to pin down. Their value depends on the edge history since the last offset-7 read, not on the present pin levels. The stimulus therefore issues an offset-7 read before every pin pattern, which gives each pattern a known empty starting state. The bench then predicts the step latch from the previous and present STEP# level. Rising WGATE# edges are produced on purpose after a clear to show that they leave bit 2 at 0.

// File: rtl/fdc_regs_pkg.sv
`timescale 1ns/1ps
package fdc_regs_pkg;
  typedef enum logic [1:0] {
    MODE_AT  = 2'b00,
    MODE_PS2 = 2'b01,
    MODE_M30 = 2'b10,
    MODE_AT2 = 2'b11
  } fdc_mode_e;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int RATE_W = 2;
  localparam int PRE_W  = 3;
  localparam int DOR_W  = 6;
  localparam int TAPE_W = 2;
  localparam logic [RATE_W-1:0] RATE_RST = 2'b10;

  localparam logic [ADDR_W-1:0] OFS_STA  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_STB  = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_DOR  = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_TAPE = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_RATE = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_CFG  = 3'd7;

  // pins whose edges are tracked (low indices of the synchronizer)
  localparam int EV_N      = 4;
  localparam int EV_WDATA  = 0;
  localparam int EV_RDATA  = 1;
  localparam int EV_STEP   = 2;
  localparam int EV_WGATE  = 3;
  localparam int TOG_N     = 2;
  localparam int EDGE_ONLY = 2;  // wdata/rdata: edges only, no level
  localparam int PIN_N     = 10;

  // level view indices (synchronizer bits above EDGE_ONLY)
  localparam int LV_STEP   = 0;
  localparam int LV_WGATE  = 1;
  localparam int LV_DIR    = 2;
  localparam int LV_HDSEL  = 3;
  localparam int LV_TRK0   = 4;
  localparam int LV_INDEX  = 5;
  localparam int LV_WPT    = 6;
  localparam int LV_DSKCHG = 7;
endpackage

// File: rtl/fdc_pin_sync.sv
`timescale 1ns/1ps
module fdc_pin_sync #(
  parameter int WIDTH     = 10,
  parameter int STAGES    = 2,
  parameter int EDGE_W    = 4,
  parameter int EDGE_ONLY = 2,
  parameter logic [EDGE_W-1:0] EDGE_POL = 4'b0011,  // 1 = rising, 0 = falling
  localparam int LVL_W    = WIDTH - EDGE_ONLY
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  pins_n,
  output logic [LVL_W-1:0]  level_o,
  output logic [EDGE_W-1:0] edge_o
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q, pipe_d;
  logic [EDGE_W-1:0]            prev_q;
  logic [WIDTH-1:0]             synced;

  always_comb begin
    pipe_d[0] = pins_n;
    for (int i = 1; i < STAGES; i++) pipe_d[i] = pipe_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      prev_q <= '1;
    end else begin
      pipe_q <= pipe_d;
      prev_q <= synced[EDGE_W-1:0];
    end
  end

  assign synced  = pipe_q[STAGES-1];
  assign level_o = synced[WIDTH-1:EDGE_ONLY];

  for (genvar g = 0; g < EDGE_W; g++) begin : g_edge
    if (EDGE_POL[g]) begin : g_rise
      assign edge_o[g] = synced[g] & ~prev_q[g];
    end else begin : g_fall
      assign edge_o[g] = ~synced[g] & prev_q[g];
    end
  end

  // edges come from the synchronized value and its one-cycle-old copy
  assert_edge_src_R14: assert property (@(posedge clk) disable iff (!rst_n)
    (synced[EDGE_W-1:0] == prev_q) |-> (edge_o == '0));
endmodule

// File: rtl/fdc_activity.sv
`timescale 1ns/1ps
module fdc_activity
  import fdc_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EV_N-1:0]  ev,
  input  logic             clr,
  output logic [TOG_N-1:0] tog,
  output logic [EV_N-1:0]  stk
);
  logic [TOG_N-1:0] tog_q, tog_d;
  logic [EV_N-1:0]  stk_q, stk_d;

  always_comb begin
    tog_d = tog_q ^ ev[TOG_N-1:0];
    stk_d = ev | (stk_q & ~{EV_N{clr}});  // a new edge wins over the clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_q <= '0;
      stk_q <= '0;
    end else begin
      tog_q <= tog_d;
      stk_q <= stk_d;
    end
  end

  assign tog = tog_q;
  assign stk = stk_q;

  assert_sticky_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && ev == '0) |=> (stk == '0));
  assert_sticky_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr) |=> ((stk & $past(stk)) == $past(stk)));
  assert_toggle_wd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev[EV_WDATA] |=> (tog[0] != $past(tog[0])));
endmodule

// File: rtl/fdc_ctrl_regs.sv
`timescale 1ns/1ps
module fdc_ctrl_regs
  import fdc_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  fdc_mode_e         mode,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [DOR_W-1:0]  dor,
  output logic [TAPE_W-1:0] tape_sel,
  output logic [RATE_W-1:0] rate,
  output logic [PRE_W-1:0]  precomp,
  output logic              pwr_down,
  output logic              nopre,
  output logic              soft_rst
);
  logic [DOR_W-1:0]  dor_q, dor_d;
  logic [TAPE_W-1:0] tape_q, tape_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic              pd_q, pd_d, nopre_q, nopre_d, soft_q, soft_d;

  always_comb begin
    dor_d   = dor_q;
    tape_d  = tape_q;
    rate_d  = rate_q;
    pre_d   = pre_q;
    pd_d    = pd_q;
    nopre_d = nopre_q;
    soft_d  = 1'b0;
    if (wr) begin
      unique case (addr)
        OFS_DOR:  dor_d  = wdata[DOR_W-1:0];
        OFS_TAPE: tape_d = wdata[TAPE_W-1:0];
        OFS_RATE: begin
          rate_d = wdata[RATE_W-1:0];
          pre_d  = wdata[RATE_W +: PRE_W];
          pd_d   = wdata[6];
          soft_d = wdata[7];
        end
        OFS_CFG: begin
          rate_d = wdata[RATE_W-1:0];
          if (mode == MODE_M30) nopre_d = wdata[2];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dor_q   <= '0;
      tape_q  <= '0;
      rate_q  <= RATE_RST;
      pre_q   <= '0;
      pd_q    <= 1'b0;
      nopre_q <= 1'b0;
      soft_q  <= 1'b0;
    end else begin
      dor_q   <= dor_d;
      tape_q  <= tape_d;
      rate_q  <= rate_d;
      pre_q   <= pre_d;
      pd_q    <= pd_d;
      nopre_q <= nopre_d;
      soft_q  <= soft_d;
    end
  end

  assign dor      = dor_q;
  assign tape_sel = tape_q;
  assign rate     = rate_q;
  assign precomp  = pre_q;
  assign pwr_down = pd_q;
  assign nopre    = nopre_q;
  assign soft_rst = soft_q;

  assert_rate_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && (addr == OFS_RATE || addr == OFS_CFG)) |=> $stable(rate));
  assert_precomp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == OFS_RATE) |=> ($stable(precomp) && $stable(pwr_down)));
  assert_softrst_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !soft_rst);
  assert_nopre_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == OFS_CFG && mode == MODE_M30) |=> $stable(nopre));
  assert_dor_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && addr == OFS_DOR) |=> $stable(dor));
endmodule

// File: rtl/fdc_host_regs.sv
`timescale 1ns/1ps
module fdc_host_regs
  import fdc_regs_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              host_rd,
  input  logic              host_wr,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic [BYTE_W-1:0] msr_in,
  input  logic              step_n,
  input  logic              dir_n,
  input  logic              hdsel_n,
  input  logic              wgate_n,
  input  logic              wdata_n,
  input  logic              rdata_n,
  input  logic              trk0_n,
  input  logic              index_n,
  input  logic              wpt_n,
  input  logic              dskchg_n,
  input  logic              irq_pend,
  input  logic              drq,
  output logic              motor_a,
  output logic              drive_sel_a,
  output logic              ctrl_reset,
  output logic              dma_irq_en,
  output logic [RATE_W-1:0] data_rate,
  output logic [PRE_W-1:0]  precomp,
  output logic              power_down
);
  localparam int LVL_W = PIN_N - EDGE_ONLY;

  fdc_mode_e         mode_e;
  logic [PIN_N-1:0]  pins_n;
  logic [LVL_W-1:0]  lv;
  logic [EV_N-1:0]   ev;
  logic [TOG_N-1:0]  tog;
  logic [EV_N-1:0]   stk;
  logic [DOR_W-1:0]  dor;
  logic [TAPE_W-1:0] tape_sel;
  logic [RATE_W-1:0] rate;
  logic              nopre, soft_rst, clr_act;

  assign mode_e = fdc_mode_e'(mode);
  assign pins_n = {dskchg_n, wpt_n, index_n, trk0_n, hdsel_n, dir_n,
                   wgate_n, step_n, rdata_n, wdata_n};

  fdc_pin_sync #(
    .WIDTH(PIN_N), .STAGES(SYNC_STAGES), .EDGE_W(EV_N),
    .EDGE_ONLY(EDGE_ONLY), .EDGE_POL(4'b0011)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_n(pins_n), .level_o(lv), .edge_o(ev)
  );

  assign clr_act = host_rd && (host_addr == OFS_CFG);

  fdc_activity u_act (
    .clk(clk), .rst_n(rst_n), .ev(ev), .clr(clr_act), .tog(tog), .stk(stk)
  );

  fdc_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .wr(host_wr), .addr(host_addr),
    .wdata(host_wdata), .dor(dor), .tape_sel(tape_sel), .rate(rate),
    .precomp(precomp), .pwr_down(power_down), .nopre(nopre), .soft_rst(soft_rst)
  );

  assign motor_a     = dor[4];
  assign drive_sel_a = (dor[1:0] == 2'b00);
  assign ctrl_reset  = ~dor[2] | soft_rst;
  assign dma_irq_en  = (mode_e == MODE_PS2) ? 1'b1 : dor[3];
  assign data_rate   = rate;

  always_comb begin
    host_rdata = 8'h00;
    unique case (host_addr)
      OFS_STA: begin
        if (mode_e == MODE_PS2)
          host_rdata = {irq_pend, 1'b1, ~lv[LV_STEP], lv[LV_TRK0], ~lv[LV_HDSEL],
                        lv[LV_INDEX], lv[LV_WPT], ~lv[LV_DIR]};
        else if (mode_e == MODE_M30)
          host_rdata = {irq_pend, drq, stk[EV_STEP], ~lv[LV_TRK0], lv[LV_HDSEL],
                        ~lv[LV_INDEX], ~lv[LV_WPT], lv[LV_DIR]};
        else
          host_rdata = 8'hFF;
      end
      OFS_STB: begin
        if (mode_e == MODE_PS2)
          host_rdata = {2'b11, dor[0], tog[EV_WDATA], tog[EV_RDATA],
                        ~lv[LV_WGATE], 1'b0, dor[4]};
        else if (mode_e == MODE_M30)
          host_rdata = {2'b11, ~drive_sel_a, stk[EV_WDATA], stk[EV_RDATA],
                        stk[EV_WGATE], 2'b11};
        else
          host_rdata = 8'hFF;
      end
      OFS_DOR:  host_rdata = {2'b00, dor};
      OFS_TAPE: host_rdata = {4'b0011, 2'b11, tape_sel};
      OFS_RATE: host_rdata = msr_in;
      OFS_CFG: begin
        if (mode_e == MODE_PS2)
          host_rdata = {~lv[LV_DSKCHG], 4'b1111, rate, rate[1] ^ rate[0]};
        else if (mode_e == MODE_M30)
          host_rdata = {lv[LV_DSKCHG], 3'b000, dor[3], nopre, rate};
        else
          host_rdata = {~lv[LV_DSKCHG], 7'b0};
      end
      default: host_rdata = 8'h00;
    endcase
  end

  assert_softrst_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == OFS_RATE && host_wdata[7]) |=> ctrl_reset);
  assert_motor_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr == OFS_DOR) |=> $stable(motor_a));
endmodule

// File: tb/test_fdc_host_regs.sv
`timescale 1ns/1ps
module test_fdc_host_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'h00;
  logic       rd = 1'b0, wr = 1'b0;
  logic [7:0] rdata;
  logic [7:0] msr = 8'h00;
  logic step_n = 1, dir_n = 1, hdsel_n = 1, wgate_n = 1, wdata_n = 1, rdata_n = 1;
  logic trk0_n = 1, index_n = 1, wpt_n = 1, dskchg_n = 1, irq = 0, drq = 0;
  logic motor_a, drive_sel_a, ctrl_reset, dma_irq_en, power_down;
  logic [1:0] data_rate;
  logic [2:0] precomp;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [5:0] dor_m = 6'd0;
  logic [1:0] rate_m = 2'b10;
  logic [2:0] pc_m = 3'd0;
  logic       pd_m = 1'b0, nopre_m = 1'b0;

  always #10 clk = ~clk;

  fdc_host_regs i_fdc_host_regs (
    .clk(clk), .rst_n(rst_n), .mode(mode), .host_addr(addr), .host_wdata(wdata),
    .host_rd(rd), .host_wr(wr), .host_rdata(rdata), .msr_in(msr),
    .step_n(step_n), .dir_n(dir_n), .hdsel_n(hdsel_n), .wgate_n(wgate_n),
    .wdata_n(wdata_n), .rdata_n(rdata_n), .trk0_n(trk0_n), .index_n(index_n),
    .wpt_n(wpt_n), .dskchg_n(dskchg_n), .irq_pend(irq), .drq(drq),
    .motor_a(motor_a), .drive_sel_a(drive_sel_a), .ctrl_reset(ctrl_reset),
    .dma_irq_en(dma_irq_en), .data_rate(data_rate), .precomp(precomp),
    .power_down(power_down)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    if (a == 3'd2) dor_m = d[5:0];
    if (a == 3'd4) begin rate_m = d[1:0]; pc_m = d[4:2]; pd_m = d[6]; end
    if (a == 3'd7) begin rate_m = d[1:0]; if (mode == 2'b10) nopre_m = d[2]; end
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, e;
    logic prev_step;
    tick(3); rst_n = 1'b1; tick(1);

    // R1 reset state
    chk("R1 ctrl_reset", {7'b0, ctrl_reset}, 8'h01);
    chk("R1 motor_a", {7'b0, motor_a}, 8'h00);
    chk("R1 data_rate", {6'b0, data_rate}, 8'h02);
    chk("R1 precomp", {5'b0, precomp}, 8'h00);
    chk("R1 power_down", {7'b0, power_down}, 8'h00);
    chk("R1 dma_irq_en", {7'b0, dma_irq_en}, 8'h00);
    mode = 2'b10; peek(0, d); chk("R1 off0 m30", d, 8'h09);

    // R14 synchronizer latency
    mode = 2'b01; @(negedge clk); trk0_n = 1'b0;
    tick(1); peek(0, d); chk("R14 one edge", {7'b0, d[4]}, 8'h01);
    tick(1); peek(0, d); chk("R14 two edges", {7'b0, d[4]}, 8'h00);
    trk0_n = 1'b1; tick(4);

    // R2, R3 sweep of offset 0
    mode = 2'b00; peek(0, d); chk("R2 off0 at", d, 8'hFF);
    peek(1, d); chk("R2 off1 at", d, 8'hFF);
    mode = 2'b11; peek(0, d); chk("R2 off0 at2", d, 8'hFF);
    for (int md = 1; md <= 2; md++) begin
      mode = md[1:0];
      prev_step = step_n;
      for (int p = 0; p < 256; p++) begin
        logic [7:0] pv;
        pv = p[7:0];
        rd_reg(7, d);
        step_n = pv[0]; dir_n = pv[1]; hdsel_n = pv[2]; trk0_n = pv[3];
        index_n = pv[4]; wpt_n = pv[5]; irq = pv[6]; drq = pv[7];
        tick(3);
        peek(0, d);
        if (md == 1) begin
          e = {pv[6], 1'b1, ~pv[0], pv[3], ~pv[2], pv[4], pv[5], ~pv[1]};
          chk("R2 off0 ps2", d, e);
        end else begin
          e = {pv[6], pv[7], prev_step & ~pv[0], ~pv[3], pv[2], ~pv[4], ~pv[5], pv[1]};
          chk("R3 off0 m30", d, e);
        end
        prev_step = pv[0];
      end
    end
    step_n = 1; dir_n = 1; hdsel_n = 1; trk0_n = 1; index_n = 1; wpt_n = 1;
    irq = 0; drq = 0; tick(4); rd_reg(7, d);

    // R6, R7 drive control sweep
    for (int md = 0; md < 4; md++) begin
      mode = md[1:0];
      for (int v = 0; v < 64; v++) begin
        logic [5:0] vv;
        vv = v[5:0];
        wr_reg(2, {2'b11, vv});
        peek(2, d); chk("R6 dor read", d, {2'b00, vv});
        chk("R6 motor_a", {7'b0, motor_a}, {7'b0, vv[4]});
        chk("R6 ctrl_reset", {7'b0, ctrl_reset}, {7'b0, ~vv[2]});
        chk("R6 drive_sel_a", {7'b0, drive_sel_a}, {7'b0, vv[1:0] == 2'b00});
        chk("R7 dma gate", {7'b0, dma_irq_en}, {7'b0, (md == 1) ? 1'b1 : vv[3]});
      end
    end

    // R4 PS/2 toggles
    wr_reg(2, 8'h15);
    mode = 2'b01;
    begin
      int wd_c = 0, rd_c = 0;
      for (int k = 0; k < 6; k++) begin
        wdata_n = 0; tick(4); wdata_n = 1; tick(4); wd_c++;
        if (k % 2 == 1) begin rdata_n = 0; tick(4); rdata_n = 1; tick(4); rd_c++; end
        peek(1, d);
        e = {2'b11, dor_m[0], wd_c[0], rd_c[0], ~wgate_n, 1'b0, dor_m[4]};
        chk("R4 off1 ps2", d, e);
      end
      wgate_n = 0; tick(4); peek(1, d);
      chk("R4 wgate level", d, {2'b11, dor_m[0], wd_c[0], rd_c[0], 1'b1, 1'b0, dor_m[4]});
      wgate_n = 1; tick(4);
    end

    // R5 Model 30 sticky bits
    mode = 2'b10; rd_reg(7, d);
    peek(1, d); e = {2'b11, ~(dor_m[1:0] == 2'b00), 3'b000, 2'b11};
    chk("R5 cleared", d, e);
    wdata_n = 0; tick(4); peek(1, d); chk("R5 wdata fall ignored", d, e);
    wdata_n = 1; tick(4); e[4] = 1'b1; peek(1, d); chk("R5 wdata rise", d, e);
    rdata_n = 0; tick(4); rdata_n = 1; tick(4); e[3] = 1'b1;
    peek(1, d); chk("R5 rdata rise", d, e);
    wgate_n = 0; tick(4); e[2] = 1'b1; peek(1, d); chk("R5 wgate fall", d, e);
    wgate_n = 1; tick(4); peek(1, d); chk("R5 sticky holds", d, e);
    rd_reg(7, d); e[4:2] = 3'b000; peek(1, d); chk("R5 clear on read", d, e);
    wgate_n = 0; tick(4); rd_reg(7, d); wgate_n = 1; tick(4);
    peek(1, d); chk("R5 wgate rise ignored", d, e);

    // R8 tape select
    for (int t = 0; t < 4; t++) begin
      wr_reg(3, {6'b101010, t[1:0]});
      peek(3, d); chk("R8 tape read", d, {6'b001111, t[1:0]});
    end

    // R9 rate select register and soft reset
    wr_reg(2, 8'h04);
    for (int v = 0; v < 16; v++) begin
      logic [3:0] vv;
      vv = v[3:0];
      wr_reg(4, {1'b0, vv[3], 1'b0, vv[2:0], 2'b01});
      chk("R9 precomp", {5'b0, precomp}, {5'b0, vv[2:0]});
      chk("R9 power_down", {7'b0, power_down}, {7'b0, vv[3]});
      chk("R9 no pulse", {7'b0, ctrl_reset}, 8'h00);
    end
    wr_reg(4, 8'h80 | 8'h0E);
    chk("R9 soft reset on", {7'b0, ctrl_reset}, 8'h01);
    chk("R9 precomp with soft", {5'b0, precomp}, 8'h03);
    tick(1); chk("R9 soft reset off", {7'b0, ctrl_reset}, 8'h00);

    // R10 two paths to the data rate
    mode = 2'b01;
    for (int r = 0; r < 4; r++) begin
      wr_reg(4, {6'b000000, r[1:0]});
      chk("R10 via off4", {6'b0, data_rate}, {6'b0, r[1:0]});
      wr_reg(2, 8'h04);
      chk("R10 held", {6'b0, data_rate}, {6'b0, r[1:0]});
      wr_reg(7, {6'b000000, ~r[1:0]});
      chk("R10 via off7", {6'b0, data_rate}, {6'b0, ~r[1:0]});
    end

    // R11 offset 7 read
    wr_reg(2, 8'h0C);
    for (int md = 0; md < 4; md++) begin
      for (int dc = 0; dc < 2; dc++) begin
        for (int r = 0; r < 4; r++) begin
          logic [1:0] rr;
          rr = r[1:0];
          mode = 2'b01; wr_reg(7, {6'b0, rr});
          mode = md[1:0]; dskchg_n = dc[0]; tick(3);
          peek(7, d);
          if (md == 1) e = {~dc[0], 4'b1111, rr, rr[1] ^ rr[0]};
          else if (md == 2) e = {dc[0], 3'b000, dor_m[3], nopre_m, rr};
          else e = {~dc[0], 7'b0};
          chk("R11 off7 read", d, e);
        end
      end
    end
    dskchg_n = 1; tick(3);

    // R12 nopre
    mode = 2'b10; wr_reg(7, 8'h06);
    peek(7, d); chk("R12 nopre set", {7'b0, d[2]}, 8'h01);
    chk("R12 precomp untouched", {5'b0, precomp}, {5'b0, pc_m});
    chk("R12 pd untouched", {7'b0, power_down}, {7'b0, pd_m});
    mode = 2'b01; wr_reg(7, 8'h02);
    mode = 2'b10; peek(7, d); chk("R12 ps2 write ignored", {7'b0, d[2]}, 8'h01);
    wr_reg(7, 8'h02); peek(7, d); chk("R12 nopre clear", {7'b0, d[2]}, 8'h00);

    // R13 external status and unused offsets
    for (int m = 0; m < 8; m++) begin
      msr = 8'h1D * m[7:0] + 8'h41;
      peek(4, d); chk("R13 msr pass", d, 8'h1D * m[7:0] + 8'h41);
    end
    peek(5, d); chk("R13 off5", d, 8'h00);
    peek(6, d); chk("R13 off6", d, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule